// File: doc/BRIEF.md
# Converter Sample Queue with Exact Status Flags

This block is a four-deep first-in first-out store for 12-bit converter results. Two producers feed it: the converter's result port and a debug write port. Both push into the same queue, and the converter wins if both present a sample in the same cycle. A processor-side read port pops samples in arrival order. The oldest sample and its valid strobe are visible combinationally in the same cycle as the read request.

The queue reports its state on five flags: empty, almost-full (three or more stored), full, and the sticky error flags overflow and underflow. A level event, `evt_avail`, signals that at least one sample is waiting. The flags always come from the true occupancy. A pop and a push in the same cycle therefore leave every flag exactly as it was.

A command strobe with a 2-bit code controls the queue. Code 3 flushes the queue and clears both error flags, and it overrides any read or write in that cycle. The other code values do nothing.

Top module: `smpl_fifo`

## Requirements
- R1: While `rst_n` is low and after its release, `flg_empty` is 1, `evt_avail` is 0 and `flg_afull`, `flg_full`, `flg_ovf`, `flg_udf` and `rd_valid` are 0.
- R2: After each clock edge the occupancy flags match the stored count n: `flg_empty` = (n==0), `flg_afull` = (n>=3), `flg_full` = (n==4).
- R3: A read with the queue non-empty raises `rd_valid` in that cycle, and `rd_data` then carries the oldest stored sample. Samples leave in the order they entered.
- R4: A read and a write accepted in the same cycle leave the occupancy unchanged, so no status flag changes. This holds at n=1, n=3 and n=4, and at n=4 overflow stays clear.
- R5: A read while the queue is empty gives `rd_valid`=0, does not change the occupancy, and sets `flg_udf`. `flg_udf` stays set until a flush or a reset.
- R6: A write while the queue is full with no read in the same cycle drops the incoming sample, keeps the stored samples, and sets `flg_ovf`. `flg_ovf` stays set until a flush or a reset.
- R7: `cmd_wr` with `cmd_code`==3 empties the queue and clears `flg_ovf` and `flg_udf` by the next cycle. A read or write in the same cycle is discarded and `rd_valid` stays 0. Codes 0 to 2 have no effect.
- R8: `cnv_valid` pushes `cnv_data` and `dbg_valid` pushes `dbg_data`. When both are high in one cycle only `cnv_data` is stored.
- R9: `evt_avail` is the inverse of `flg_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnv_valid | input | 1 | Converter result strobe |
| cnv_data | input | 12 | Converter result |
| dbg_valid | input | 1 | Debug write strobe |
| dbg_data | input | 12 | Debug write sample |
| rd_req | input | 1 | Processor pop request |
| rd_valid | output | 1 | Pop accepted, `rd_data` valid |
| rd_data | output | 12 | Oldest stored sample |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 2 | Command value, 3 = flush |
| flg_empty | output | 1 | Occupancy is zero |
| flg_afull | output | 1 | Occupancy is three or more |
| flg_full | output | 1 | Occupancy is four |
| flg_ovf | output | 1 | Sticky overflow |
| flg_udf | output | 1 | Sticky underflow |
| evt_avail | output | 1 | Sample available event |

## Verification
The assertions are checked on every cycle. They confirm that a same-cycle pop and push leave the whole status word stable, that overflow and underflow are set by the right conditions and then stay set, and that a flush always ends with an empty, error-free queue and aligned pointers. Data ordering, the converter's priority over a debug write, the dropped sample on overflow and the inert command codes depend on values, so only the bench's model can show them. The bench runs directed scenarios at occupancies one, three and four, followed by a long random mix.

// File: rtl/smpl_fifo_pkg.sv
package smpl_fifo_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'd0,
    CMD_RSVA  = 2'd1,
    CMD_RSVB  = 2'd2,
    CMD_FLUSH = 2'd3
  } fifo_cmd_e;

  typedef struct packed {
    logic empty;
    logic afull;
    logic full;
    logic ovf;
    logic udf;
  } fifo_stat_t;
endpackage

// File: rtl/smpl_fifo_store.sv
module smpl_fifo_store #(
  parameter int DW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [DW-1:0] mem_q [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_comb begin
    wp_d = wp_q;
    rp_d = rp_q;
    if (clr) begin
      wp_d = '0;
      rp_d = '0;
    end else begin
      if (push) wp_d = bump(wp_q);
      if (pop)  rp_d = bump(rp_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_en;
    assign slot_en = push && !clr && (wp_q == PW'(g));
    always_ff @(posedge clk) begin
      if (slot_en) mem_q[g] <= wdata;
    end
  end

  assign rdata = mem_q[rp_q];

  // R7: pointers realign after a flush
  p_ptr_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (wp_q == '0) && (rp_q == '0));
endmodule

// File: rtl/smpl_fifo_ctrl.sv
module smpl_fifo_ctrl
  import smpl_fifo_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic       rd_req,
  input  logic       flush,
  output logic       push,
  output logic       pop,
  output fifo_stat_t stat
);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int AF_LVL = DEPTH - 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          full_w, empty_w;

  assign full_w  = (cnt_q == CW'(DEPTH));
  assign empty_w = (cnt_q == '0);
  assign pop     = rd_req && !empty_w && !flush;
  assign push    = wr_req && (!full_w || pop) && !flush;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    udf_d = udf_q;
    if (flush) begin
      cnt_d = '0;
      ovf_d = 1'b0;
      udf_d = 1'b0;
    end else begin
      unique case ({push, pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
      if (wr_req && full_w && !pop) ovf_d = 1'b1;
      if (rd_req && empty_w)        udf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
    end
  end

  assign stat.empty = empty_w;
  assign stat.afull = (cnt_q >= CW'(AF_LVL));
  assign stat.full  = full_w;
  assign stat.ovf   = ovf_q;
  assign stat.udf   = udf_q;

  p_full_afull_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat.full |-> stat.afull && !stat.empty);
  p_rw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(stat));
  p_udf_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && stat.empty && !flush) |=> stat.udf);
  p_udf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.udf && !flush) |=> stat.udf);
  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && stat.full && !rd_req && !flush) |=> stat.ovf && stat.full);
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat.ovf && !flush) |=> stat.ovf);
  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> stat.empty && !stat.ovf && !stat.udf);
endmodule

// File: rtl/smpl_fifo.sv
module smpl_fifo
  import smpl_fifo_pkg::*;
#(
  parameter int DW    = 12,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnv_valid,
  input  logic [DW-1:0] cnv_data,
  input  logic          dbg_valid,
  input  logic [DW-1:0] dbg_data,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          cmd_wr,
  input  logic [1:0]    cmd_code,
  output logic          flg_empty,
  output logic          flg_afull,
  output logic          flg_full,
  output logic          flg_ovf,
  output logic          flg_udf,
  output logic          evt_avail
);
  logic          wr_req, flush, push, pop;
  logic [DW-1:0] wdata;
  fifo_stat_t    stat;

  assign wr_req = cnv_valid || dbg_valid;
  assign wdata  = cnv_valid ? cnv_data : dbg_data;
  assign flush  = cmd_wr && (fifo_cmd_e'(cmd_code) == CMD_FLUSH);

  smpl_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_req (wr_req),
    .rd_req (rd_req),
    .flush  (flush),
    .push   (push),
    .pop    (pop),
    .stat   (stat)
  );

  smpl_fifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .clr   (flush),
    .wdata (wdata),
    .rdata (rd_data)
  );

  assign rd_valid  = pop;
  assign flg_empty = stat.empty;
  assign flg_afull = stat.afull;
  assign flg_full  = stat.full;
  assign flg_ovf   = stat.ovf;
  assign flg_udf   = stat.udf;
  assign evt_avail = !stat.empty;

  // R5: no data is handed out from an empty queue
  p_rdv_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !flg_empty);
  // R9: event and empty flag never agree
  p_evt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_avail != flg_empty);
endmodule

// File: tb/tb_smpl_fifo.sv
module tb_smpl_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnv_valid, dbg_valid, rd_req, cmd_wr;
  logic [11:0] cnv_data, dbg_data;
  logic [1:0]  cmd_code;
  logic        rd_valid;
  logic [11:0] rd_data;
  logic        flg_empty, flg_afull, flg_full, flg_ovf, flg_udf, evt_avail;

  int    n_chk = 0;
  int    n_bad = 0;
  int    q[$];
  bit    m_ovf, m_udf;
  string dtag = "R3";

  always #10 clk = ~clk;

  smpl_fifo dut (.*);

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic bit e_empty(int n); return n == 0; endfunction
  function automatic bit e_afull(int n); return n >= 3; endfunction
  function automatic bit e_full(int n);  return n == 4; endfunction

  task automatic check_flags();
    chk("R2 empty", flg_empty, e_empty(q.size()));
    chk("R2 afull", flg_afull, e_afull(q.size()));
    chk("R2 full",  flg_full,  e_full(q.size()));
    chk("R6 ovf",   flg_ovf,   m_ovf);
    chk("R5 udf",   flg_udf,   m_udf);
    chk("R9 evt",   evt_avail, !e_empty(q.size()));
  endtask

  // Drive at the falling edge, check, then advance one cycle.
  task automatic step(input bit cv, input int cd, input bit dv, input int dd,
                      input bit rd, input bit cw, input int cc);
    bit fl, pp, wr, was_full;
    cnv_valid = cv; cnv_data = 12'(cd);
    dbg_valid = dv; dbg_data = 12'(dd);
    rd_req = rd; cmd_wr = cw; cmd_code = 2'(cc);
    #2;
    check_flags();
    fl = cw && (cc == 3);
    pp = rd && (q.size() > 0) && !fl;
    chk(fl ? "R7 rd_valid" : "R5 rd_valid", rd_valid, pp);
    if (pp && rd_valid) chk(dtag, rd_data, q[0]);
    if (fl) begin
      q.delete(); m_ovf = 0; m_udf = 0;
    end else begin
      wr = cv || dv;
      was_full = q.size() == 4;
      if (rd && q.size() == 0) m_udf = 1;
      if (pp) void'(q.pop_front());
      if (wr) begin
        if (was_full && !pp) m_ovf = 1;
        else q.push_back(cv ? (cd & 12'hFFF) : (dd & 12'hFFF));
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    rst_n = 0; cnv_valid = 0; dbg_valid = 0; rd_req = 0; cmd_wr = 0;
    cnv_data = 0; dbg_data = 0; cmd_code = 0;
    m_ovf = 0; m_udf = 0;
    repeat (3) @(negedge clk);
    chk("R1 empty in reset", flg_empty, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 empty", flg_empty, 1);
    chk("R1 afull", flg_afull, 0);
    chk("R1 full", flg_full, 0);
    chk("R1 ovf", flg_ovf, 0);
    chk("R1 udf", flg_udf, 0);
    chk("R1 evt", evt_avail, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // R4 at occupancy 1
    step(1, 12'h101, 0, 0, 0, 0, 0);
    step(1, 12'h102, 0, 0, 1, 0, 0);
    chk("R4 empty held at n=1", flg_empty, 0);
    // R4 at occupancy 3
    step(0, 0, 1, 12'h203, 0, 0, 0);
    step(1, 12'h104, 0, 0, 0, 0, 0);
    step(1, 12'h105, 0, 0, 1, 0, 0);
    chk("R4 afull held at n=3", flg_afull, 1);
    // R4 at occupancy 4
    step(1, 12'h106, 0, 0, 0, 0, 0);
    step(1, 12'h107, 0, 0, 1, 0, 0);
    chk("R4 full held at n=4", flg_full, 1);
    chk("R4 no overflow at n=4", flg_ovf, 0);
    // R6 overflow drops sample, keeps contents
    step(0, 0, 1, 12'hBAD, 0, 0, 0);
    chk("R6 ovf set", flg_ovf, 1);
    chk("R6 still full", flg_full, 1);
    // Inert command codes
    step(0, 0, 0, 0, 0, 1, 2);
    chk("R7 code 2 inert", flg_full, 1);
    step(0, 0, 0, 0, 0, 1, 1);
    chk("R7 code 1 inert", flg_ovf, 1);
    // drain, checking order (R3) and that 0xBAD was dropped (R6)
    repeat (4) step(0, 0, 0, 0, 1, 0, 0);
    chk("R6 drained to empty", flg_empty, 1);
    // R5 underflow
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R5 udf set", flg_udf, 1);
    chk("R5 still empty", flg_empty, 1);
    idle();
    chk("R5 udf sticky", flg_udf, 1);
    // R8 converter priority
    step(1, 12'h3C3, 1, 12'h5A5, 0, 0, 0);
    chk("R8 single push", flg_empty, 0);
    dtag = "R8";
    step(0, 0, 0, 0, 1, 0, 0);
    dtag = "R3";
    chk("R8 one sample only", flg_empty, 1);
    // R7 flush with simultaneous read and write
    step(1, 12'h011, 0, 0, 0, 0, 0);
    step(1, 12'h012, 0, 0, 1, 1, 3);
    chk("R7 flush empty", flg_empty, 1);
    chk("R7 flush udf clear", flg_udf, 0);
    chk("R7 flush ovf clear", flg_ovf, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit cv = ($urandom % 100) < 45;
      bit dv = ($urandom % 100) < 20;
      bit rd = ($urandom % 100) < 45;
      bit cw = ($urandom % 100) < 4;
      step(cv, int'($urandom % 4096), dv, int'($urandom % 4096), rd, cw,
           int'($urandom % 4));
    end
    idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule